// File: doc/BRIEF.md
# Paged Program Counter Unit

This unit holds the 13-bit instruction address of a small processor core whose instruction store holds up to 8K words of 14 bits. Each cycle the address either holds or is reloaded from one of several sources. The sources are a sequential step, a software write to the visible low byte, an 11-bit jump or call target, a full 13-bit return address taken from an external stack, and the fixed interrupt entry point. Instruction decoding and the return-address stack are outside the unit. The unit only receives strobes and data from them.

Software reaches only the low eight address bits directly. The upper five bits come from a separate page latch that software writes. A low-byte write copies all five latch bits into the upper address. A jump or call takes only the top two latch bits, which select one of four 2K pages. A return ignores the latch and loads all 13 bits. Push and pop activity never disturbs the latch.

Top module: `pcu_top`

## Requirements
- R1: While reset is asserted, and after it is released, the address reads 0000h and both readbacks read 00h. Reset asserts asynchronously. Its release passes through two register stages, so strobes take effect from the third rising edge after `rst_n` rises.
- R2: An increment strobe adds one to the address, and 1FFFh steps to 0000h.
- R3: A low-byte write loads address bits 7:0 from the write data and bits 12:8 from page latch bits 4:0.
- R4: A branch strobe loads address bits 10:0 from the target and bits 12:11 from page latch bits 4:3.
- R5: A return strobe loads all 13 bits from the return data, whatever the latch holds.
- R6: An interrupt strobe loads address 0004h.
- R7: A latch write stores data bits 4:0. The latch readback returns them in bits 4:0 and returns zero in bits 7:5.
- R8: When several strobes arrive together, the interrupt wins, then return, then branch, then low-byte write, then increment.
- R9: The low-byte readback always equals address bits 7:0.
- R10: Interrupt, return and branch loads leave the page latch unchanged.
- R11: When a latch write and a low-byte write arrive in the same cycle, the address takes the latch value held before that write.
- R12: With no strobe, the address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_i | input | 1 | Sequential step strobe |
| lo_we_i | input | 1 | Low-byte write strobe |
| lo_wdata_i | input | 8 | Low-byte write data |
| lat_we_i | input | 1 | Page latch write strobe |
| lat_wdata_i | input | 8 | Page latch write data |
| br_i | input | 1 | Jump/call strobe |
| br_tgt_i | input | 11 | Jump/call target within a page |
| irq_i | input | 1 | Interrupt entry strobe |
| ret_i | input | 1 | Return strobe |
| ret_addr_i | input | 13 | Return address popped from the stack |
| pc_o | output | 13 | Current instruction address |
| lo_rdata_o | output | 8 | Low-byte readback |
| lat_rdata_o | output | 8 | Page latch readback |

## Verification
Every strobe is sampled at a rising edge, and its effect on `pc_o`, `lo_rdata_o` and `lat_rdata_o` appears right after that same edge, one cycle later. The exception is reset: its assertion clears the outputs at once, and its release delays strobes by two further edges. The bench applies each stimulus on a falling edge, lets exactly one rising edge pass, and reads the outputs on the following falling edge before it drives anything new. For the reset release, the bench holds an increment strobe and checks the address after the second edge, where it must still read zero, and again after the third edge, where it must read one.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  // Source selected for the next program address
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_INC  = 3'd1,
    SRC_LOW  = 3'd2,
    SRC_BR   = 3'd3,
    SRC_RET  = 3'd4,
    SRC_IRQ  = 3'd5
  } pc_src_e;

endpackage

// File: rtl/pcu_rst_sync.sv
module pcu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/pcu_src_arb.sv
module pcu_src_arb
  import pcu_pkg::*;
(
  input  logic    irq_i,
  input  logic    ret_i,
  input  logic    br_i,
  input  logic    lo_we_i,
  input  logic    inc_i,
  output pc_src_e src_o
);

  // Fixed priority: interrupt, return, branch, low write, step
  always_comb begin
    if (irq_i)        src_o = SRC_IRQ;
    else if (ret_i)   src_o = SRC_RET;
    else if (br_i)    src_o = SRC_BR;
    else if (lo_we_i) src_o = SRC_LOW;
    else if (inc_i)   src_o = SRC_INC;
    else              src_o = SRC_HOLD;
  end

endmodule

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [HI_W-1:0]   lat_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [HI_W-1:0] lat_q;
  logic [HI_W-1:0] lat_d;
  logic            unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:HI_W];

  always_comb begin
    lat_d = lat_q;
    if (we_i) lat_d = wdata_i[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_q <= '0;
    else if (we_i) lat_q <= lat_d;
  end

  assign lat_o   = lat_q;
  assign rdata_o = {{(DATA_W-HI_W){1'b0}}, lat_q};

endmodule

// File: rtl/pcu_next.sv
module pcu_next
  import pcu_pkg::*;
#(
  parameter int          PC_W    = 13,
  parameter int          BYTE_W  = 8,
  parameter int          BR_W    = 11,
  parameter logic [12:0] IRQ_VEC = 13'h0004
) (
  input  pc_src_e                src_i,
  input  logic [PC_W-1:0]        pc_i,
  input  logic [PC_W-BYTE_W-1:0] lat_i,
  input  logic [BYTE_W-1:0]      lo_wdata_i,
  input  logic [BR_W-1:0]        br_tgt_i,
  input  logic [PC_W-1:0]        ret_addr_i,
  output logic [PC_W-1:0]        pc_o
);

  localparam int HI_W   = PC_W - BYTE_W;
  localparam int PAGE_W = PC_W - BR_W;

  logic [PAGE_W-1:0] page;
  assign page = lat_i[HI_W-1 -: PAGE_W];

  always_comb begin
    unique case (src_i)
      SRC_IRQ:  pc_o = IRQ_VEC[PC_W-1:0];
      SRC_RET:  pc_o = ret_addr_i;
      SRC_BR:   pc_o = {page, br_tgt_i};
      SRC_LOW:  pc_o = {lat_i, lo_wdata_i};
      SRC_INC:  pc_o = pc_i + PC_W'(1);
      default:  pc_o = pc_i;
    endcase
  end

endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int          PC_W      = 13,
  parameter int          BYTE_W    = 8,
  parameter int          BR_W      = 11,
  parameter int          SYNC_STG  = 2,
  parameter logic [12:0] RST_VEC   = 13'h0000,
  parameter logic [12:0] IRQ_VEC   = 13'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              lo_we_i,
  input  logic [BYTE_W-1:0] lo_wdata_i,
  input  logic              lat_we_i,
  input  logic [BYTE_W-1:0] lat_wdata_i,
  input  logic              br_i,
  input  logic [BR_W-1:0]   br_tgt_i,
  input  logic              irq_i,
  input  logic              ret_i,
  input  logic [PC_W-1:0]   ret_addr_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [BYTE_W-1:0] lo_rdata_o,
  output logic [BYTE_W-1:0] lat_rdata_o
);

  localparam int HI_W = PC_W - BYTE_W;

  logic            core_rst_n;
  pc_src_e         src;
  logic [HI_W-1:0] lat;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic            pc_en;

  pcu_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  pcu_src_arb u_arb (
    .irq_i   (irq_i),
    .ret_i   (ret_i),
    .br_i    (br_i),
    .lo_we_i (lo_we_i),
    .inc_i   (inc_i),
    .src_o   (src)
  );

  pcu_page_latch #(.DATA_W(BYTE_W), .HI_W(HI_W)) u_lat (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .we_i    (lat_we_i),
    .wdata_i (lat_wdata_i),
    .lat_o   (lat),
    .rdata_o (lat_rdata_o)
  );

  pcu_next #(
    .PC_W(PC_W), .BYTE_W(BYTE_W), .BR_W(BR_W), .IRQ_VEC(IRQ_VEC)
  ) u_next (
    .src_i      (src),
    .pc_i       (pc_q),
    .lat_i      (lat),
    .lo_wdata_i (lo_wdata_i),
    .br_tgt_i   (br_tgt_i),
    .ret_addr_i (ret_addr_i),
    .pc_o       (pc_d)
  );

  assign pc_en = (src != SRC_HOLD);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) pc_q <= RST_VEC[PC_W-1:0];
    else if (pc_en)  pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign lo_rdata_o = pc_q[BYTE_W-1:0];

endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
  parameter int PC_W   = 13,
  parameter int BYTE_W = 8,
  parameter int BR_W   = 11
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              inc_i,
  input logic              lo_we_i,
  input logic [BYTE_W-1:0] lo_wdata_i,
  input logic              lat_we_i,
  input logic [BYTE_W-1:0] lat_wdata_i,
  input logic              br_i,
  input logic [BR_W-1:0]   br_tgt_i,
  input logic              irq_i,
  input logic              ret_i,
  input logic [PC_W-1:0]   ret_addr_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [BYTE_W-1:0] lat_rdata_o
);

  localparam int HI_W   = PC_W - BYTE_W;
  localparam int PAGE_W = PC_W - BR_W;

  // R2 and R8: step only when nothing stronger is present
  a_r2_step: assert property (@(posedge clk) disable iff (!core_rst_n)
    (inc_i && !lo_we_i && !br_i && !ret_i && !irq_i) |=> pc_o == $past(pc_o) + PC_W'(1));

  // R3
  a_r3_low_write: assert property (@(posedge clk) disable iff (!core_rst_n)
    (lo_we_i && !br_i && !ret_i && !irq_i) |=>
      pc_o == {$past(lat_rdata_o[HI_W-1:0]), $past(lo_wdata_i)});

  // R4
  a_r4_branch: assert property (@(posedge clk) disable iff (!core_rst_n)
    (br_i && !ret_i && !irq_i) |=>
      pc_o == {$past(lat_rdata_o[HI_W-1 -: PAGE_W]), $past(br_tgt_i)});

  // R5
  a_r5_return: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ret_i && !irq_i) |=> pc_o == $past(ret_addr_i));

  // R6
  a_r6_irq: assert property (@(posedge clk) disable iff (!core_rst_n)
    irq_i |=> pc_o == PC_W'(4));

  // R7
  a_r7_latch_store: assert property (@(posedge clk) disable iff (!core_rst_n)
    lat_we_i |=> lat_rdata_o == {{(BYTE_W-HI_W){1'b0}}, $past(lat_wdata_i[HI_W-1:0])});

  // R10
  a_r10_latch_kept: assert property (@(posedge clk) disable iff (!core_rst_n)
    !lat_we_i |=> $stable(lat_rdata_o));

  // R12
  a_r12_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!inc_i && !lo_we_i && !br_i && !ret_i && !irq_i) |=> $stable(pc_o));

endmodule

bind pcu_top pcu_chk #(.PC_W(PC_W), .BYTE_W(BYTE_W), .BR_W(BR_W)) chk_i (
  .clk         (clk),
  .core_rst_n  (core_rst_n),
  .inc_i       (inc_i),
  .lo_we_i     (lo_we_i),
  .lo_wdata_i  (lo_wdata_i),
  .lat_we_i    (lat_we_i),
  .lat_wdata_i (lat_wdata_i),
  .br_i        (br_i),
  .br_tgt_i    (br_tgt_i),
  .irq_i       (irq_i),
  .ret_i       (ret_i),
  .ret_addr_i  (ret_addr_i),
  .pc_o        (pc_o),
  .lat_rdata_o (lat_rdata_o)
);

// File: tb/pcu_top_tb.sv
module pcu_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  typedef struct packed {
    logic        inc;
    logic        lo_we;
    logic [7:0]  lo_d;
    logic        lat_we;
    logic [7:0]  lat_d;
    logic        br;
    logic [10:0] tgt;
    logic        irq;
    logic        ret;
    logic [12:0] raddr;
    logic [12:0] e_pc;
    logic [7:0]  e_lat;
    logic [3:0]  req;
  } vec_t;

  // inc lo_we lo_d lat_we lat_d br tgt irq ret raddr | exp_pc exp_lat req
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,11'h000,1'b0,1'b0,13'h0000, 13'h0001,8'h00,4'd2},  // R2 step
    '{1'b0,1'b0,8'h00,1'b1,8'hFF,1'b0,11'h000,1'b0,1'b0,13'h0000, 13'h0001,8'h1F,4'd7},  // R7 upper bits zero, R12 hold
    '{1'b0,1'b1,8'h34,1'b0,8'h00,1'b0,11'h000,1'b0,1'b0,13'h0000, 13'h1F34,8'h1F,4'd3},  // R3
    '{1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,11'h000,1'b0,1'b0,13'h0000, 13'h1F35,8'h1F,4'd2},  // R2
    '{1'b0,1'b0,8'h00,1'b1,8'h08,1'b0,11'h000,1'b0,1'b0,13'h0000, 13'h1F35,8'h08,4'd12}, // R12
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,11'h123,1'b0,1'b0,13'h0000, 13'h0923,8'h08,4'd4},  // R4 page 1
    '{1'b0,1'b0,8'h00,1'b1,8'h18,1'b0,11'h000,1'b0,1'b0,13'h0000, 13'h0923,8'h18,4'd7},  // R7
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,11'h7FF,1'b0,1'b0,13'h0000, 13'h1FFF,8'h18,4'd4},  // R4 page 3
    '{1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,11'h000,1'b0,1'b0,13'h0000, 13'h0000,8'h18,4'd2},  // R2 wrap
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,11'h000,1'b0,1'b1,13'h0ABC, 13'h0ABC,8'h18,4'd5},  // R5, R10
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,11'h000,1'b1,1'b0,13'h0000, 13'h0004,8'h18,4'd6},  // R6, R10
    '{1'b1,1'b1,8'h99,1'b0,8'h00,1'b1,11'h222,1'b0,1'b1,13'h1555, 13'h1555,8'h18,4'd8},  // R8 ret wins
    '{1'b1,1'b1,8'h99,1'b0,8'h00,1'b1,11'h001,1'b0,1'b0,13'h0000, 13'h1801,8'h18,4'd8},  // R8 br wins
    '{1'b1,1'b1,8'h7E,1'b0,8'h00,1'b0,11'h000,1'b0,1'b0,13'h0000, 13'h187E,8'h18,4'd8},  // R8 low wins
    '{1'b1,1'b1,8'h11,1'b0,8'h00,1'b1,11'h333,1'b1,1'b1,13'h1234, 13'h0004,8'h18,4'd8},  // R8 irq wins
    '{1'b0,1'b1,8'h10,1'b1,8'h05,1'b0,11'h000,1'b0,1'b0,13'h0000, 13'h1810,8'h05,4'd11}, // R11
    '{1'b0,1'b1,8'hAA,1'b0,8'h00,1'b0,11'h000,1'b0,1'b0,13'h0000, 13'h05AA,8'h05,4'd3},  // R3
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,11'h000,1'b0,1'b1,13'h1FFF, 13'h1FFF,8'h05,4'd5},  // R5 ignores latch
    '{1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,11'h000,1'b0,1'b0,13'h0000, 13'h0000,8'h05,4'd2}   // R2 wrap
  };

  logic        clk;
  logic        rst_n;
  logic        inc_i, lo_we_i, lat_we_i, br_i, irq_i, ret_i;
  logic [7:0]  lo_wdata_i, lat_wdata_i;
  logic [10:0] br_tgt_i;
  logic [12:0] ret_addr_i;
  logic [12:0] pc_o;
  logic [7:0]  lo_rdata_o, lat_rdata_o;

  int checks;
  int failures;
  bit done;

  pcu_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .inc_i(inc_i), .lo_we_i(lo_we_i), .lo_wdata_i(lo_wdata_i),
    .lat_we_i(lat_we_i), .lat_wdata_i(lat_wdata_i),
    .br_i(br_i), .br_tgt_i(br_tgt_i), .irq_i(irq_i),
    .ret_i(ret_i), .ret_addr_i(ret_addr_i),
    .pc_o(pc_o), .lo_rdata_o(lo_rdata_o), .lat_rdata_o(lat_rdata_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    inc_i = 0; lo_we_i = 0; lat_we_i = 0; br_i = 0; irq_i = 0; ret_i = 0;
    lo_wdata_i = '0; lat_wdata_i = '0; br_tgt_i = '0; ret_addr_i = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    idle();
    rst_n = 1'b0;
    #1;
    // R1: outputs zero while reset is held
    check(1, "pc in reset", 32'(pc_o), 32'h0);
    check(1, "latch in reset", 32'(lat_rdata_o), 32'h0);
    check(1, "low byte in reset", 32'(lo_rdata_o), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Vector table: drive on falling edge, one rising edge, read on next falling edge
    for (int i = 0; i < NV; i++) begin
      inc_i = VECS[i].inc; lo_we_i = VECS[i].lo_we; lo_wdata_i = VECS[i].lo_d;
      lat_we_i = VECS[i].lat_we; lat_wdata_i = VECS[i].lat_d;
      br_i = VECS[i].br; br_tgt_i = VECS[i].tgt; irq_i = VECS[i].irq;
      ret_i = VECS[i].ret; ret_addr_i = VECS[i].raddr;
      @(negedge clk);
      check(int'(VECS[i].req), $sformatf("vector %0d pc", i), 32'(pc_o), 32'(VECS[i].e_pc));
      check(int'(VECS[i].req), $sformatf("vector %0d latch", i), 32'(lat_rdata_o),
            32'(VECS[i].e_lat));
      // R9: low readback mirrors the address
      check(9, $sformatf("vector %0d low byte", i), 32'(lo_rdata_o), 32'(VECS[i].e_pc[7:0]));
    end

    // R12: several idle cycles keep the address
    idle();
    lo_we_i = 1; lo_wdata_i = 8'h5C;
    @(negedge clk);
    idle();
    repeat (4) @(negedge clk);
    check(12, "hold over idle cycles", 32'(pc_o), 32'h055C);

    // R1: asynchronous reset in the middle of a run
    #2 rst_n = 1'b0;
    #1;
    check(1, "pc after async reset", 32'(pc_o), 32'h0);
    check(1, "latch after async reset", 32'(lat_rdata_o), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    inc_i = 1;
    repeat (2) @(negedge clk);
    check(1, "step blocked during release", 32'(pc_o), 32'h0);
    @(negedge clk);
    check(1, "first step after release", 32'(pc_o), 32'h1);
    idle();
    @(negedge clk);

    // R10: branch with latch untouched, then verify latch still zero
    br_i = 1; br_tgt_i = 11'h4AB;
    @(negedge clk);
    idle();
    check(4, "branch with page 0", 32'(pc_o), 32'h04AB);
    check(10, "latch after branch", 32'(lat_rdata_o), 32'h0);

    finish_run();
  end

endmodule